// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block drives a 12-bit converter that has a three-wire serial port. It drives chip select low, makes a serial clock from the system clock, and reads the returned bits on each rising edge of the serial clock. When the frame ends it presents the word as a sign-extended 16-bit value. The converter changes its data line on falling edges. Its first valid bit after chip select falls is a null bit. The 12 data bits that follow come out MSB first. If chip select stays low, the converter then repeats the word LSB first, without repeating B0.

A host requests a conversion with `start`. The mode input is sampled at that moment. Single mode ends the frame right after B0. Double mode keeps chip select low for the echo of B1 to B11 and compares each echoed bit with the MSB-first copy. The serial clock half period is a count of system clocks. Software picks it so that the serial clock stays between 0.8 MHz and 4.8 MHz. For example, with a 50 MHz system clock any setting from 6 to 31 is in range. A second count sets how long chip select stays high between frames. `busy` stays high for that whole interval.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset `cs_n`=1, `sclk`=1, `busy`=0, `done`=0, `result`=0 and `echo_err`=0.
- R2: Each low phase and each high phase of `sclk` lasts `half_div` system clocks, and a setting of 0 acts as 1. The first falling edge comes `half_div` clocks after `cs_n` falls. `sclk` stays high whenever `cs_n` is high.
- R3: `sdata` is sampled on rising edges of `sclk`. The value at rise 2 (the null bit) is discarded. Rises 3 to 14 carry B11 down to B0.
- R4: In single mode (`dbl_mode`=0) a frame has exactly 14 falling edges. `cs_n` rises `half_div` clocks after rise 14, so there is no 15th fall. `cs_n` stays low for `half_div`*29 clocks.
- R5: In double mode (`dbl_mode`=1) a frame has exactly 25 falling edges, and rises 15 to 25 carry B1 up to B11. `cs_n` stays low for `half_div`*51 clocks.
- R6: `result` is the 12-bit two's complement word sign-extended to 16 bits. It is valid when `done` pulses high for exactly one clock, and that pulse comes in the first clock in which `cs_n` is high again.
- R7: `echo_err` is 1 with `done` if any echoed bit differs from the same bit of the MSB-first word. It is always 0 after a single-mode frame.
- R8: Between frames `cs_n` stays high for `cs_gap`+2 system clocks when `start` is held high. `busy` stays high until that interval ends.
- R9: A `start` while `busy` is 1 is ignored, including a start in the cycle of the `done` pulse.
- R10: `dbl_mode`, `half_div` and `cs_gap` are sampled when a frame starts. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, accepted when not busy |
| dbl_mode | input | 1 | 1 = also read and compare the LSB-first echo |
| half_div | input | 8 | Serial clock half period in system clocks |
| cs_gap | input | 8 | Extra chip-select high time between frames |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | Frame or inter-frame gap in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | 16 | Sign-extended conversion result |
| echo_err | output | 1 | Echo mismatch flag, valid with done |

## Verification
The end of a frame can fall in the same cycle as a new request. `done`, the rise of `cs_n` and the start of the gap all happen at once, and a `start` raised in that cycle must not open a new frame. The bench raises `start` for exactly the clock edge that follows the first sample of `done`. It then judges the result by the fact that `cs_n` never falls again during the next 40 clocks. The same pair is also provoked by holding `start` high continuously. There the bench checks that the next frame begins only after exactly `cs_gap`+2 high clocks.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2,
    ST_GAP  = 2'd3
  } rd_state_t;
endpackage

// File: rtl/adcrd_halftimer.sv
module adcrd_halftimer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] lim,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim_m1;

  assign lim_m1 = (lim == '0) ? '0 : lim - DIV_W'(1);
  assign tick   = run && (cnt == lim_m1);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end

  // R2: the counter never runs past the phase limit
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt <= lim_m1);
endmodule

// File: rtl/adcrd_capture.sv
module adcrd_capture #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              stb,
  input  logic [CNT_W-1:0]  idx,
  input  logic              bit_in,
  output logic [DATA_W-1:0] word,
  output logic              mismatch
);
  localparam int NULL_POS  = 2;
  localparam int FIRST_MSB = NULL_POS + 1;
  localparam int LAST_MSB  = NULL_POS + DATA_W;
  localparam int LAST_ECHO = LAST_MSB + DATA_W - 1;

  logic             in_word;
  logic             in_echo;
  logic [CNT_W-1:0] echo_pos;

  assign in_word  = (idx >= CNT_W'(FIRST_MSB)) && (idx <= CNT_W'(LAST_MSB));
  assign in_echo  = (idx > CNT_W'(LAST_MSB)) && (idx <= CNT_W'(LAST_ECHO));
  assign echo_pos = idx - CNT_W'(LAST_MSB);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word     <= '0;
      mismatch <= 1'b0;
    end else if (stb) begin
      if (in_word)
        word <= {word[DATA_W-2:0], bit_in};
      else if (in_echo && (bit_in != word[echo_pos[$clog2(DATA_W)-1:0]]))
        mismatch <= 1'b1;
    end
  end

  // R7: a new frame starts with a clean mismatch flag
  a_r7_clear_flag: assert property (@(posedge clk) disable iff (rst)
    clr |=> !mismatch);
  // R3: the word is frozen once the MSB-first bits are complete
  a_r3_word_frozen: assert property (@(posedge clk) disable iff (rst)
    (stb && !clr && in_echo) |=> $stable(word));
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int DATA_W = 12,
  parameter int OUT_W  = 16,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dbl_mode,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [GAP_W-1:0]  cs_gap,
  input  logic              sdata,
  output logic              cs_n,
  output logic              sclk,
  output logic              busy,
  output logic              done,
  output logic [OUT_W-1:0]  result,
  output logic              echo_err
);
  import adcrd_pkg::*;

  localparam int LAST_MSB  = 2 + DATA_W;
  localparam int LAST_ECHO = LAST_MSB + DATA_W - 1;
  localparam int CNT_W     = $clog2(LAST_ECHO + 1);

  rd_state_t         state;
  logic [CNT_W-1:0]  rise_cnt;
  logic              dbl_q;
  logic [DIV_W-1:0]  hd_q;
  logic [GAP_W-1:0]  gap_q;
  logic [GAP_W-1:0]  gcnt;
  logic              tick;
  logic              accept;
  logic              cap_stb;
  logic [CNT_W-1:0]  end_rise;
  logic [DATA_W-1:0] word;
  logic              mismatch;

  assign accept   = (state == ST_IDLE) && start;
  assign cap_stb  = (state == ST_LOW) && tick;
  assign end_rise = dbl_q ? CNT_W'(LAST_ECHO) : CNT_W'(LAST_MSB);

  adcrd_halftimer #(.DIV_W(DIV_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  ((state == ST_HIGH) || (state == ST_LOW)),
    .lim  (hd_q),
    .tick (tick)
  );

  adcrd_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .stb      (cap_stb),
    .idx      (rise_cnt + CNT_W'(1)),
    .bit_in   (sdata),
    .word     (word),
    .mismatch (mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      echo_err <= 1'b0;
      rise_cnt <= '0;
      dbl_q    <= 1'b0;
      hd_q     <= '0;
      gap_q    <= '0;
      gcnt     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          cs_n     <= 1'b0;
          sclk     <= 1'b1;
          busy     <= 1'b1;
          dbl_q    <= dbl_mode;
          hd_q     <= half_div;
          gap_q    <= cs_gap;
          rise_cnt <= '0;
          state    <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          if (rise_cnt == end_rise) begin
            cs_n     <= 1'b1;
            done     <= 1'b1;
            result   <= {{(OUT_W-DATA_W){word[DATA_W-1]}}, word};
            echo_err <= dbl_q & mismatch;
            gcnt     <= gap_q;
            state    <= ST_GAP;
          end else begin
            sclk  <= 1'b0;
            state <= ST_LOW;
          end
        end
        ST_LOW: if (tick) begin
          sclk     <= 1'b1;
          rise_cnt <= rise_cnt + CNT_W'(1);
          state    <= ST_HIGH;
        end
        default: begin
          if (gcnt == '0) begin
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            gcnt <= gcnt - GAP_W'(1);
          end
        end
      endcase
    end
  end

  // R2: serial clock idles high while chip select is high
  a_r2_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);
  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: done coincides with chip select returning high
  a_r6_done_cs: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && $past(!cs_n)));
  // R7: no echo error after a single-read frame
  a_r7_single_clean: assert property (@(posedge clk) disable iff (rst)
    (done && !dbl_q) |-> !echo_err);
  // R9: a request during the gap does not lower chip select
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && cs_n && start) |=> cs_n);
  // R10: mode is held for the whole frame
  a_r10_mode_held: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n)) |-> $stable(dbl_q));
  // R4/R5: rise count never exceeds the frame length
  a_r5_rise_bound: assert property (@(posedge clk) disable iff (rst)
    rise_cnt <= CNT_W'(LAST_ECHO));
endmodule

// File: tb/tb_adc_serial_reader.sv
module tb_adc_serial_reader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        dbl_mode = 1'b0;
  logic [7:0]  half_div = 8'd2;
  logic [7:0]  cs_gap = 8'd3;
  logic        sdata = 1'b0;
  logic        cs_n, sclk, busy, done, echo_err;
  logic [15:0] result;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  adc_serial_reader dut (
    .clk(clk), .rst(rst), .start(start), .dbl_mode(dbl_mode),
    .half_div(half_div), .cs_gap(cs_gap), .sdata(sdata),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .done(done),
    .result(result), .echo_err(echo_err)
  );

  // converter model: changes data on falling sclk
  logic [11:0] tgt_word = 12'h000;
  int          tgt_corrupt = 0;
  int          falls = 0;
  int          falls_at_end = 0;

  always @(negedge cs_n) begin
    falls = 0;
    sdata = 1'b0;
  end
  always @(posedge cs_n) falls_at_end = falls;
  always @(negedge sclk) begin
    if (!cs_n) begin
      falls = falls + 1;
      if (falls == 2)
        sdata = ~tgt_word[11];
      else if (falls >= 3 && falls <= 14)
        sdata = tgt_word[14 - falls];
      else if (falls >= 15 && falls <= 25)
        sdata = tgt_word[falls - 14] ^ ((falls - 14) == tgt_corrupt);
      else
        sdata = 1'b0;
    end
  end

  // port monitor, sampled away from the active edge
  int   low_cyc = 0, sclk_low_cyc = 0, idle_bad = 0;
  int   done_seen = 0, done_cs_bad = 0, frames = 0, hi_run = 0, last_gap = 0;
  logic prev_cs = 1'b1;
  logic [15:0] res_cap;
  logic        err_cap;

  always @(negedge clk) begin
    if (!rst) begin
      if (!cs_n) low_cyc++;
      if (!cs_n && !sclk) sclk_low_cyc++;
      if (cs_n && !sclk) idle_bad++;
      if (done) begin
        done_seen++;
        res_cap = result;
        err_cap = echo_err;
        if (!(cs_n && !prev_cs)) done_cs_bad++;
      end
      if (cs_n) hi_run++;
      else if (prev_cs) begin
        last_gap = hi_run;
        hi_run = 0;
        frames++;
      end
      prev_cs = cs_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    low_cyc = 0; sclk_low_cyc = 0; idle_bad = 0;
    done_seen = 0; done_cs_bad = 0; frames = 0;
  endtask

  // {dbl[24], corrupt[23:20], half_div[19:12], word[11:0]}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 4'd0,  8'd5, 12'h7FF},
    {1'b0, 4'd0,  8'd1, 12'h800},
    {1'b0, 4'd0,  8'd3, 12'hFFF},
    {1'b1, 4'd0,  8'd2, 12'hA5C},
    {1'b1, 4'd11, 8'd4, 12'h3C3},
    {1'b1, 4'd1,  8'd1, 12'h001},
    {1'b0, 4'd0,  8'd0, 12'h000},
    {1'b1, 4'd0,  8'd7, 12'h555}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(cs_n === 1'b1 && sclk === 1'b1, "R1 cs_n/sclk", {cs_n, sclk}, 3);
    chk(busy === 1'b0 && done === 1'b0, "R1 busy/done", {busy, done}, 0);
    chk(result === 16'h0 && echo_err === 1'b0, "R1 result", result, 0);

    for (int v = 0; v < 8; v++) begin
      logic        vd;
      logic [15:0] exp_res;
      int hd, nf;
      vd = VEC[v][24];
      tgt_corrupt = int'(VEC[v][23:20]);
      tgt_word = VEC[v][11:0];
      hd = (VEC[v][19:12] == 0) ? 1 : int'(VEC[v][19:12]);
      nf = vd ? 25 : 14;
      exp_res = {{4{tgt_word[11]}}, tgt_word};
      clear_mon();
      dbl_mode = vd; half_div = VEC[v][19:12]; cs_gap = 8'd3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      // R9/R10: request and setting changes mid-frame
      dbl_mode = ~vd; half_div = 8'd9; cs_gap = 8'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (done_seen == 0) @(negedge clk);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
      dbl_mode = vd;
      chk(res_cap === exp_res, "R3/R6 result", res_cap, exp_res);
      chk(err_cap === (vd && tgt_corrupt != 0), "R7 echo_err", err_cap, vd && tgt_corrupt != 0);
      chk(falls_at_end == nf, vd ? "R5 fall count" : "R4 fall count", falls_at_end, nf);
      chk(low_cyc == hd * (2 * nf + 1), vd ? "R5 cs low time" : "R4 cs low time", low_cyc, hd * (2 * nf + 1));
      chk(sclk_low_cyc == hd * nf, "R2 sclk low time", sclk_low_cyc, hd * nf);
      chk(idle_bad == 0, "R2 sclk idle high", idle_bad, 0);
      chk(done_seen == 1 && done_cs_bad == 0, "R6 done pulse", done_seen, 1);
      chk(frames == 1, "R9 R10 single frame", frames, 1);
    end

    // R9: start in the same cycle as done
    clear_mon();
    tgt_word = 12'h123; tgt_corrupt = 0; dbl_mode = 1'b0; half_div = 8'd1; cs_gap = 8'd4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    chk(frames == 1, "R9 start at done ignored", frames, 1);
    chk(res_cap === 16'h0123, "R6 result 0123", res_cap, 16'h0123);

    // R8: held start, gap between frames
    clear_mon();
    cs_gap = 8'd5; half_div = 8'd2; tgt_word = 12'h9AB;
    start = 1'b1;
    while (frames < 2) @(negedge clk);
    start = 1'b0;
    chk(last_gap == 7, "R8 cs high gap", last_gap, 7);
    while (done_seen < 2) @(negedge clk);
    while (busy) @(negedge clk);
    chk(res_cap === 16'hF9AB, "R6 negative result", res_cap, 16'hF9AB);
    chk(busy === 1'b0 && cs_n === 1'b1, "R8 idle after gap", {busy, cs_n}, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule